// File: doc/BRIEF.md
# Virtual Running Priority Calculator

This block derives the running priority of a virtual CPU interface from the active-priority bitmaps the hypervisor keeps. There are two bitmaps, one for group 0 and one for group 1. Each is a bank of 32-bit words. A set bit at overall position N marks an active priority level N. The block merges the two banks and finds the lowest active level. It then converts that level back into an 8-bit priority value by shifting it left by the minimum binary point plus one.

How much of each bank is meaningful depends on the number of virtual preemption bits, which is 5, 6 or 7. A bank therefore holds 1, 2 or 4 words. Words beyond that count are never looked at.

A one-cycle read strobe captures the result into an output register. The strobe is answered by a one-cycle valid pulse on the following cycle. Between reads the output holds its value.

Top module: `vrun_prio`

## Requirements
- R1: While reset is asserted, and right after it is released, `rd_valid` is 0 and `run_prio` is 0xFF.
- R2: Each cycle with `rd_req` high is followed on the next cycle by `rd_valid` high. A cycle without `rd_req` is followed by `rd_valid` low.
- R3: Only words 0 to (1 << (`pre_bits` − 5)) − 1 of each bank are scanned. `pre_bits` must lie in 5..7. Bits in higher words do not change the result.
- R4: Word w of a bank sits at bits [32w+31:32w] of its port. The group-0 and group-1 words with the same index are ORed before the search, so a bit set in either bank counts the same.
- R5: The lowest-indexed non-zero merged word decides the result. Within that word, the least-significant set bit is taken. Higher bits and higher words do not affect it.
- R6: The result is ((word index × 32 + bit position) << (`min_bp` + 1)), keeping only the low 8 bits.
- R7: When no bit is set in any scanned word, the result is 0xFF.
- R8: `run_prio` changes only in the cycle after a read strobe. Input changes without `rd_req` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe; captures the priority |
| pre_bits | input | 3 | Number of virtual preemption bits (5..7) |
| min_bp | input | 3 | Minimum binary point value |
| grp0_ap | input | 128 | Group-0 active-priority words, word w at [32w+31:32w] |
| grp1_ap | input | 128 | Group-1 active-priority words, same layout |
| rd_valid | output | 1 | One-cycle pulse: `run_prio` holds a fresh result |
| run_prio | output | 8 | Running priority, 0xFF when idle |

## Verification
The assertions take for granted that a read is only issued with a preemption-bit count of 5 to 7. They flag any read issued outside that range, because the scanned word count would then not fit the storage.

The stimulus always pairs `pre_bits` with `min_bp` = 7 − `pre_bits`, the consistent setting. The one exception is a deliberate case with a larger binary point, which exercises the 8-bit truncation. Bits placed beyond the scanned words and across both banks probe the scan limit and the merge. The strobe is only raised for one cycle, with inputs already stable, so every captured value has a single expected answer.

// File: rtl/vrun_prio.sv
module vrun_prio #(
  parameter int MAX_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int PRIO_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [2:0]                  pre_bits,
  input  logic [2:0]                  min_bp,
  input  logic [MAX_WORDS*WORD_W-1:0] grp0_ap,
  input  logic [MAX_WORDS*WORD_W-1:0] grp1_ap,
  output logic                        rd_valid,
  output logic [PRIO_W-1:0]           run_prio
);
  localparam int IDX_W = $clog2(MAX_WORDS*WORD_W);
  localparam int SH_W  = 4;
  localparam int FULL_W = IDX_W + (1 << SH_W);

  int unsigned              nwords;
  logic [MAX_WORDS-1:0]     word_en;
  logic [WORD_W-1:0]        merged [MAX_WORDS];
  logic                     hit;
  logic [IDX_W-1:0]         idx;
  logic [SH_W-1:0]          shamt;
  logic [FULL_W-1:0]        scaled;
  logic [PRIO_W-1:0]        prio_next;

  assign nwords = 32'd1 << (pre_bits - 3'd5);
  assign shamt  = {1'b0, min_bp} + 4'd1;

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    assign merged[w]  = grp0_ap[w*WORD_W +: WORD_W] | grp1_ap[w*WORD_W +: WORD_W];
    assign word_en[w] = 32'(w) < nwords;
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int w = 0; w < MAX_WORDS; w++) begin
      if (!hit && word_en[w] && merged[w] != '0) begin
        hit = 1'b1;
        for (int b = WORD_W-1; b >= 0; b--)
          if (merged[w][b]) idx = IDX_W'(w*WORD_W + b);
      end
    end
  end

  assign scaled    = FULL_W'(idx) << shamt;
  assign prio_next = hit ? scaled[PRIO_W-1:0] : {PRIO_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      run_prio <= {PRIO_W{1'b1}};
    end else begin
      rd_valid <= rd_req;
      if (rd_req) run_prio <= prio_next;
    end
  end

  // R3
  words_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (pre_bits >= 3'd5 && pre_bits <= 3'd7 && nwords <= MAX_WORDS));
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R8
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(run_prio));
  // R7
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (grp0_ap | grp1_ap) == '0) |=> run_prio == {PRIO_W{1'b1}});
endmodule

// File: tb/vrun_prio_tb.sv
module vrun_prio_tb;
  localparam int N = 12;
  localparam logic [127:0] ONE = 128'd1;

  localparam logic [2:0] V_PRE [N] = '{3'd5,3'd5,3'd5,3'd5,3'd6,3'd6,3'd7,3'd7,3'd7,3'd5,3'd6,3'd7};
  localparam logic [2:0] V_BP  [N] = '{3'd2,3'd2,3'd2,3'd2,3'd1,3'd1,3'd0,3'd0,3'd0,3'd3,3'd1,3'd0};
  localparam logic [127:0] V_G0 [N] = '{
    ONE << 0, ONE << 3, 128'd0, ONE << 32, ONE << 32, ONE << 40,
    ONE << 100, ONE << 127, 128'd0, ONE << 31, (ONE << 5) | (ONE << 60), ONE << 64};
  localparam logic [127:0] V_G1 [N] = '{
    128'd0, 128'd0, ONE << 31, 128'd0, 128'd0, ONE << 36,
    ONE << 70, 128'd0, 128'd0, 128'd0, 128'd0, ONE << 33};
  localparam logic [7:0] V_EXP [N] = '{
    8'h00, 8'h18, 8'hF8, 8'hFF, 8'h80, 8'h90, 8'h8C, 8'hFE, 8'hFF, 8'hF0, 8'h14, 8'h42};
  localparam string V_TAG [N] = '{
    "R5","R6","R4","R3","R3","R4","R5","R6","R7","R6","R5","R4"};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_req = 1'b0;
  logic [2:0]   pre_bits = 3'd5;
  logic [2:0]   min_bp = 3'd2;
  logic [127:0] grp0_ap = '0;
  logic [127:0] grp1_ap = '0;
  logic         rd_valid;
  logic [7:0]   run_prio;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vrun_prio u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .pre_bits(pre_bits),
    .min_bp(min_bp), .grp0_ap(grp0_ap), .grp1_ap(grp1_ap),
    .rd_valid(rd_valid), .run_prio(run_prio));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] p, input logic [2:0] b,
                         input logic [127:0] g0, input logic [127:0] g1,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    pre_bits = p; min_bp = b; grp0_ap = g0; grp1_ap = g1; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid === 1'b1, "R2 valid", int'(rd_valid), 1);
    chk(run_prio === exp, tag, int'(run_prio), int'(exp));
    @(negedge clk);
    chk(rd_valid === 1'b0, "R2 pulse end", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0, "R1 valid in reset", int'(rd_valid), 0);
    chk(run_prio === 8'hFF, "R1 prio in reset", int'(run_prio), 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1 valid after reset", int'(rd_valid), 0);
    chk(run_prio === 8'hFF, "R1 prio after reset", int'(run_prio), 8'hFF);

    for (int i = 0; i < N; i++)
      do_read(V_PRE[i], V_BP[i], V_G0[i], V_G1[i], V_EXP[i], V_TAG[i]);

    // R8: change inputs without a strobe, output must hold 0x42
    @(negedge clk);
    grp0_ap = ONE; grp1_ap = '0; pre_bits = 3'd5; min_bp = 3'd2;
    repeat (2) @(negedge clk);
    chk(run_prio === 8'h42, "R8 hold", int'(run_prio), 8'h42);
    chk(rd_valid === 1'b0, "R2 no strobe", int'(rd_valid), 0);

    // R3: only the bit in word 3 while four words are scanned
    do_read(3'd7, 3'd0, ONE << 96, 128'd0, 8'hC0, "R3 word3");
    // R3: same bit with two words scanned is ignored
    do_read(3'd6, 3'd1, ONE << 96, 128'd0, 8'hFF, "R3 word3 unscanned");
    // R7: bits only beyond the scan window read as idle
    do_read(3'd5, 3'd2, ONE << 64, ONE << 127, 8'hFF, "R7 idle beyond");

    // R1: reset in the middle restores idle state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(run_prio === 8'hFF, "R1 re-reset", int'(run_prio), 8'hFF);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule